// File: doc/BRIEF.md
# UART Channel Register and Command Front End

This block is the software-visible side of one UART channel. It sits on a simple byte-wide bus with a 6-bit address and a single select strobe. Behind the bus it holds two mode bytes, a status byte, an interrupt status byte with a mask, and two read-only baud divider bytes. A command byte written by software is split into three fields: a housekeeping action, a transmitter action and a receiver action. The fields are applied in that order, so one write can reset and re-enable a direction.

Data leaves through a one-byte transmit holding stage. The stage is a valid/ready source: `tx_valid` rises when the transmitter is enabled and a byte is pending. `tx_data` stays frozen while `tx_ready` is low. The byte is consumed on the first cycle that has both signals high. Data arrives through a valid/ready sink. `rx_ready` is high only while the receiver is enabled, the receive queue has room and no break is arriving. A byte is accepted on a cycle with both signals high, and the sender must hold it otherwise. A separate `rx_break` pulse stands for a line break.

A single level interrupt combines the interrupt status with the mask. The serial bit engine and baud generation are outside this block.

Top module: `uart_regfile_ctrl`

## Requirements
- R1: Reset state: both mode bytes, the interrupt status and the mask are zero. Both directions are disabled. Status reads 0x08. `irq`, `tx_valid` and `rx_ready` are low.
- R2: Offset 0x00 reads and writes the mode byte chosen by a pointer that starts at the first byte. Any write to 0x00 moves the pointer to the second byte. Command housekeeping code 1 moves it back to the first.
- R3: Status at 0x04 has bit0 = queue not empty, bit1 = queue holds FIFO_DEPTH bytes, bit2 = transmitter enabled, bit3 = no transmit byte pending. Bits 7:4 read zero.
- R4: A command written at 0x08 has housekeeping code in bits 6:4, transmitter field in bits 3:2 and receiver field in bits 1:0. In each two-bit field, 1 enables and 2 disables. The housekeeping action takes effect first, then the transmitter field, then the receiver field.
- R5: Housekeeping code 2 disables the receiver and empties the receive queue.
- R6: Housekeeping code 3 disables the transmitter and discards any pending transmit byte.
- R7: Writing 0x0C loads the transmit byte and clears status bit3. `tx_valid` is high exactly when the transmitter is enabled and a byte is pending. `tx_data` is stable while `tx_ready` is low. Status bit3 sets on the handshake cycle. A disabled transmitter keeps its byte.
- R8: `rx_ready` is high only when the receiver is enabled, fewer than FIFO_DEPTH bytes are held and `rx_break` is low. Accepted bytes read back from 0x0C oldest first. A read of 0x0C with an empty queue returns 0 and changes nothing.
- R9: An `rx_break` pulse sets interrupt status bit2 and queues a zero byte even when the receiver is disabled. With a full queue, that zero byte replaces the newest entry. Housekeeping code 5 clears bit2.
- R10: Interrupt status at 0x14 has bit0 = transmitter enabled, bit1 = queue full when bit6 of the first mode byte is set and otherwise queue not empty, bit2 = break seen, and other bits zero.
- R11: A write to 0x14 sets the mask. `irq` is high exactly when a status bit and its mask bit are both set. It follows from registered state, so it moves in the cycle after the causing write or stream event.
- R12: Reads of 0x08, 0x10 and unmapped offsets return 0. Reads of 0x18 and 0x1C return DIV_UPPER and DIV_LOWER. Writes to 0x04, 0x10, 0x18, 0x1C and unmapped offsets change nothing.
- R13: Housekeeping codes 0, 4, 6 and 7, and field value 3 or 0 in either direction field, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Downstream takes the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive queue accepts the byte |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Line break event, one pulse per break |
| irq | output | 1 | Level interrupt |

## Verification
A wrong queue count or a lost enable shows up the next cycle at `rx_ready`, `tx_valid` or `irq`. It also shows in the status byte on the next read, so checks follow each write with a status or interrupt read. A shifting or ordering fault in the receive queue shows only when bytes are read back. Because of that, every accepted byte goes into a scoreboard, and every read of 0x0C is matched against it. A fault in the command field order shows after a single combined command, such as reset-and-enable, as a wrong enable or a stale pending byte.

// File: rtl/uart_rc_pkg.sv
package uart_rc_pkg;

  localparam int BYTE_W = 8;

  localparam logic [5:0] OFS_MODE = 6'h00;
  localparam logic [5:0] OFS_STAT = 6'h04;
  localparam logic [5:0] OFS_CMD  = 6'h08;
  localparam logic [5:0] OFS_DATA = 6'h0C;
  localparam logic [5:0] OFS_PORT = 6'h10;
  localparam logic [5:0] OFS_INT  = 6'h14;
  localparam logic [5:0] OFS_DIVH = 6'h18;
  localparam logic [5:0] OFS_DIVL = 6'h1C;

  typedef enum logic [2:0] {
    HK_NOP     = 3'd0,
    HK_PTR_RST = 3'd1,
    HK_RX_RST  = 3'd2,
    HK_TX_RST  = 3'd3,
    HK_ERR_RST = 3'd4,
    HK_BRK_CLR = 3'd5,
    HK_BRK_ON  = 3'd6,
    HK_BRK_OFF = 3'd7
  } hk_op_e;

  typedef enum logic [1:0] {
    DIR_KEEP = 2'd0,
    DIR_ON   = 2'd1,
    DIR_OFF  = 2'd2,
    DIR_RSVD = 2'd3
  } dir_op_e;

  typedef struct packed {
    logic ptr_rst;
    logic brk_clr;
    logic tx_enable;
    logic tx_disable;
    logic tx_flush;
    logic rx_enable;
    logic rx_disable;
    logic rx_flush;
  } cmd_act_t;

endpackage

// File: rtl/uart_rc_cmd.sv
module uart_rc_cmd
  import uart_rc_pkg::*;
(
  input  logic        fire,
  input  logic [7:0]  cmd,
  output cmd_act_t    act
);

  hk_op_e  hk;
  dir_op_e tx_f;
  dir_op_e rx_f;
  logic    unused_cmd_msb;

  assign hk   = hk_op_e'(cmd[6:4]);
  assign tx_f = dir_op_e'(cmd[3:2]);
  assign rx_f = dir_op_e'(cmd[1:0]);
  assign unused_cmd_msb = cmd[7];

  // Fields resolve in order: housekeeping, then transmitter, then receiver.
  // A later enable overrides a disable implied by an earlier reset.
  always_comb begin
    act = '0;
    if (fire) begin
      act.ptr_rst  = (hk == HK_PTR_RST);
      act.brk_clr  = (hk == HK_BRK_CLR);
      act.rx_flush = (hk == HK_RX_RST);
      act.tx_flush = (hk == HK_TX_RST);

      act.tx_enable  = (tx_f == DIR_ON);
      act.tx_disable = !act.tx_enable && ((hk == HK_TX_RST) || (tx_f == DIR_OFF));

      act.rx_enable  = (rx_f == DIR_ON);
      act.rx_disable = !act.rx_enable && ((hk == HK_RX_RST) || (rx_f == DIR_OFF));
    end
  end

endmodule

// File: rtl/uart_rc_rxq.sv
module uart_rc_rxq #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          nonempty,
  output logic          full
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [W-1:0]  mem   [DEPTH];
  logic [W-1:0]  mem_n [DEPTH];
  logic [CW-1:0] count, cnt_base, cnt_pop, cnt_n, wr_idx;
  logic          pop_eff;

  assign nonempty = (count != '0);
  assign full     = (count == DEPTH_C);
  assign head     = mem[0];

  always_comb begin
    cnt_base = flush ? '0 : count;
    pop_eff  = pop && (cnt_base != '0);
    cnt_pop  = cnt_base - CW'(pop_eff);
    // A push into a full queue replaces the newest entry.
    wr_idx   = (cnt_pop == DEPTH_C) ? DEPTH_C - 1'b1 : cnt_pop;
    cnt_n    = (push && cnt_pop != DEPTH_C) ? cnt_pop + 1'b1 : cnt_pop;
    for (int i = 0; i < DEPTH; i++) begin
      if (pop_eff && i < DEPTH - 1) mem_n[i] = mem[i + 1];
      else                          mem_n[i] = mem[i];
      if (push && wr_idx == CW'(i)) mem_n[i] = push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      count <= cnt_n;
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_n[i];
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);

  assert_pop_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush && nonempty) |=> (count == $past(count) - 1'b1));

  assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> full);

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !push) |=> !nonempty);

endmodule

// File: rtl/uart_rc_txhold.sv
module uart_rc_txhold #(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_data,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic          flush,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [W-1:0]  tx_data,
  output logic          enabled,
  output logic          empty
);

  logic [W-1:0] hold;
  logic         handshake;

  assign tx_valid  = enabled && !empty;
  assign tx_data   = hold;
  assign handshake = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      enabled <= 1'b0;
      empty   <= 1'b1;
    end else begin
      if (en_set)      enabled <= 1'b1;
      else if (en_clr) enabled <= 1'b0;

      if (load) begin
        hold  <= load_data;
        empty <= 1'b0;
      end else if (flush || handshake) begin
        empty <= 1'b1;
      end
    end
  end

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !load && !en_clr && !flush) |=> (tx_valid && $stable(tx_data)));

  assert_consume_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && !load) |=> !tx_valid);

  assert_flush_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !load) |=> empty);

endmodule

// File: rtl/uart_regfile_ctrl.sv
module uart_regfile_ctrl
  import uart_rc_pkg::*;
#(
  parameter int         FIFO_DEPTH = 4,
  parameter logic [7:0] DIV_UPPER  = 8'h12,
  parameter logic [7:0] DIV_LOWER  = 8'h34
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_break,
  output logic        irq
);

  localparam int RXINT_SEL_BIT = 6;

  logic        wr_en, rd_en;
  logic [7:0]  mode_a, mode_b, int_mask;
  logic        mode_ptr, brk_seen, rx_en;
  cmd_act_t    act;
  logic        q_nonempty, q_full, q_push, q_pop;
  logic [7:0]  q_head, q_wdata;
  logic        tx_en, tx_empty;
  logic [7:0]  status, int_stat;

  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  uart_rc_cmd u_cmd (
    .fire (wr_en && bus_addr == OFS_CMD),
    .cmd  (bus_wdata),
    .act  (act)
  );

  assign rx_ready = rx_en && !q_full && !rx_break;
  assign q_push   = (rx_valid && rx_ready) || rx_break;
  assign q_wdata  = rx_break ? '0 : rx_data;
  assign q_pop    = rd_en && bus_addr == OFS_DATA && q_nonempty;

  uart_rc_rxq #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (act.rx_flush),
    .push      (q_push),
    .push_data (q_wdata),
    .pop       (q_pop),
    .head      (q_head),
    .nonempty  (q_nonempty),
    .full      (q_full)
  );

  uart_rc_txhold #(.W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_en && bus_addr == OFS_DATA),
    .load_data (bus_wdata),
    .en_set    (act.tx_enable),
    .en_clr    (act.tx_disable),
    .flush     (act.tx_flush),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .enabled   (tx_en),
    .empty     (tx_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_a   <= '0;
      mode_b   <= '0;
      mode_ptr <= 1'b0;
      int_mask <= '0;
      brk_seen <= 1'b0;
      rx_en    <= 1'b0;
    end else begin
      if (wr_en && bus_addr == OFS_MODE) begin
        if (mode_ptr) mode_b <= bus_wdata;
        else          mode_a <= bus_wdata;
        mode_ptr <= 1'b1;
      end else if (act.ptr_rst) begin
        mode_ptr <= 1'b0;
      end

      if (wr_en && bus_addr == OFS_INT) int_mask <= bus_wdata;

      if (rx_break)         brk_seen <= 1'b1;
      else if (act.brk_clr) brk_seen <= 1'b0;

      if (act.rx_enable)       rx_en <= 1'b1;
      else if (act.rx_disable) rx_en <= 1'b0;
    end
  end

  assign status   = {4'b0000, tx_empty, tx_en, q_full, q_nonempty};
  assign int_stat = {5'b00000, brk_seen,
                     mode_a[RXINT_SEL_BIT] ? q_full : q_nonempty,
                     tx_en};
  assign irq      = |(int_stat & int_mask);

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (bus_addr)
        OFS_MODE: bus_rdata = mode_ptr ? mode_b : mode_a;
        OFS_STAT: bus_rdata = status;
        OFS_DATA: bus_rdata = q_nonempty ? q_head : '0;
        OFS_INT:  bus_rdata = int_stat;
        OFS_DIVH: bus_rdata = DIV_UPPER;
        OFS_DIVL: bus_rdata = DIV_LOWER;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assert_ptr_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFS_MODE) |=> mode_ptr);

  assert_break_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> (int_stat[2] && q_nonempty));

  assert_mask_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFS_INT && bus_wdata == 8'h00) |=> !irq);

  assert_rx_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !q_pop && !act.rx_flush) |=> !rx_ready);

  assert_stat_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && bus_addr == OFS_STAT |-> bus_rdata[7:4] == 4'b0000);

endmodule

// File: tb/tb_uart_regfile_ctrl.sv
`timescale 1ns/1ps
module tb_uart_regfile_ctrl;

  localparam int CYC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic       rx_break = 1'b0;
  logic       irq;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;
  logic [7:0] tx_exp_q[$];
  logic [7:0] rx_exp_q[$];

  always #(CYC/2) clk = ~clk;

  uart_regfile_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_break(rx_break), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic rd_rx(input string tag);
    logic [7:0] v, e;
    rd(6'h0C, v);
    e = (rx_exp_q.size() != 0) ? rx_exp_q.pop_front() : 8'h00;
    check(tag, v, e);
  endtask

  task automatic send_rx(input string tag, input logic [7:0] d, input logic acc_exp);
    logic acc;
    rx_valid = 1'b1; rx_data = d;
    #1 acc = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
    if (acc) rx_exp_q.push_back(d);
    check(tag, {7'd0, acc}, {7'd0, acc_exp});
  endtask

  task automatic pulse_break();
    rx_break = 1'b1;
    @(negedge clk);
    rx_break = 1'b0;
  endtask

  task automatic send_tx(input logic [7:0] d);
    tx_exp_q.push_back(d);
    wr(6'h0C, d);
  endtask

  // Transmit monitor: sample between edges, pop and compare on each handshake.
  always begin
    @(negedge clk);
    #5;
    if (rst_n && tx_valid && tx_ready) begin
      if (tx_exp_q.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R7: unexpected tx byte %02h expected none", tx_data);
      end else begin
        check("R7 tx byte", tx_data, tx_exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CYC * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 status", 6'h04, 8'h08);
    rd_chk("R1 isr", 6'h14, 8'h00);
    rd_chk("R1 mode a", 6'h00, 8'h00);
    check("R1 irq/tx_valid/rx_ready", {5'd0, irq, tx_valid, rx_ready}, 8'h00);

    // R2 mode pointer
    wr(6'h00, 8'hA5);
    wr(6'h00, 8'h3C);
    rd_chk("R2 second mode", 6'h00, 8'h3C);
    wr(6'h00, 8'h11);
    rd_chk("R2 stays second", 6'h00, 8'h11);
    wr(6'h08, 8'h10);
    rd_chk("R2 back to first", 6'h00, 8'hA5);

    // R12 unmapped and ignored offsets
    rd_chk("R12 cmd reads 0", 6'h08, 8'h00);
    rd_chk("R12 port reads 0", 6'h10, 8'h00);
    rd_chk("R12 div upper", 6'h18, 8'h12);
    rd_chk("R12 div lower", 6'h1C, 8'h34);
    rd_chk("R12 unmapped", 6'h20, 8'h00);
    wr(6'h04, 8'hFF); wr(6'h10, 8'hFF); wr(6'h18, 8'hFF); wr(6'h3C, 8'hFF);
    rd_chk("R12 status kept", 6'h04, 8'h08);
    rd_chk("R12 isr kept", 6'h14, 8'h00);
    rd_chk("R12 div kept", 6'h18, 8'h12);
    check("R12 irq kept", {7'd0, irq}, 8'h00);

    // R7 transmit holding and handshake
    wr(6'h0C, 8'h5A);
    rd_chk("R7 pending while disabled", 6'h04, 8'h00);
    check("R7 no valid while disabled", {7'd0, tx_valid}, 8'h00);
    wr(6'h08, 8'h04);
    rd_chk("R3 tx enabled pending", 6'h04, 8'h04);
    for (int i = 0; i < 3; i++) begin
      check("R7 valid held", {7'd0, tx_valid}, 8'h01);
      check("R7 data held", tx_data, 8'h5A);
      @(negedge clk);
    end
    tx_exp_q.push_back(8'h5A);
    tx_ready = 1'b1;
    @(negedge clk);
    rd_chk("R7 empty after handshake", 6'h04, 8'h0C);
    send_tx(8'hA1); send_tx(8'hB2); send_tx(8'hC3);
    @(negedge clk);
    rd_chk("R7 burst drained", 6'h04, 8'h0C);
    tx_ready = 1'b0;
    wr(6'h08, 8'h08);
    rd_chk("R4 tx disable", 6'h04, 8'h08);
    wr(6'h0C, 8'h77);
    rd_chk("R7 disabled keeps byte", 6'h04, 8'h00);
    wr(6'h08, 8'h30);
    rd_chk("R6 tx reset", 6'h04, 8'h08);
    wr(6'h08, 8'h04);
    check("R6 byte discarded", {7'd0, tx_valid}, 8'h00);
    rd_chk("R6 status after enable", 6'h04, 8'h0C);

    // R8 receive stream
    wr(6'h08, 8'h01);
    check("R8 rx_ready enabled", {7'd0, rx_ready}, 8'h01);
    send_rx("R8 accept 1", 8'h11, 1'b1);
    send_rx("R8 accept 2", 8'h22, 1'b1);
    rd_chk("R3 rx ready bit", 6'h04, 8'h0D);
    rd_rx("R8 first out");
    rd_rx("R8 second out");
    rd_chk("R3 queue empty", 6'h04, 8'h0C);
    rd_rx("R8 empty read zero");
    rd_chk("R8 empty read no effect", 6'h04, 8'h0C);
    send_rx("R8 fill", 8'h31, 1'b1);
    send_rx("R8 fill", 8'h32, 1'b1);
    send_rx("R8 fill", 8'h33, 1'b1);
    send_rx("R8 fill", 8'h34, 1'b1);
    rd_chk("R3 full bit", 6'h04, 8'h0F);
    send_rx("R8 refused when full", 8'h99, 1'b0);

    // R9 break with full queue
    pulse_break();
    rx_exp_q[rx_exp_q.size() - 1] = 8'h00;
    rd_chk("R9 isr break", 6'h14, 8'h07);
    check("R11 masked off", {7'd0, irq}, 8'h00);
    wr(6'h14, 8'h04);
    check("R11 break unmasked", {7'd0, irq}, 8'h01);
    wr(6'h08, 8'h50);
    check("R9 break cleared irq", {7'd0, irq}, 8'h00);
    rd_chk("R9 isr after clear", 6'h14, 8'h03);

    // R10 receive interrupt source select
    wr(6'h08, 8'h10);
    wr(6'h00, 8'h40);
    wr(6'h14, 8'h02);
    check("R10 full selected irq", {7'd0, irq}, 8'h01);
    rd_rx("R8 out after break");
    check("R10 not full irq low", {7'd0, irq}, 8'h00);
    rd_chk("R10 isr ready not full", 6'h14, 8'h01);
    send_rx("R8 refill", 8'h55, 1'b1);
    check("R10 full again irq", {7'd0, irq}, 8'h01);

    // R5 receiver reset and R4 ordering
    wr(6'h08, 8'h20);
    rx_exp_q.delete();
    rd_chk("R5 rx reset status", 6'h04, 8'h0C);
    check("R5 rx disabled", {6'd0, rx_ready, irq}, 8'h00);
    wr(6'h08, 8'h21);
    check("R4 reset then enable rx", {7'd0, rx_ready}, 8'h01);
    send_rx("R8 accept after reset", 8'h66, 1'b1);
    wr(6'h08, 8'h21);
    rx_exp_q.delete();
    rd_chk("R4 flush before enable", 6'h04, 8'h0C);
    check("R4 rx still enabled", {7'd0, rx_ready}, 8'h01);
    wr(6'h0C, 8'hEE);
    check("R7 valid with ready low", {7'd0, tx_valid}, 8'h01);
    wr(6'h08, 8'h34);
    check("R4 tx reset then enable drops byte", {7'd0, tx_valid}, 8'h00);
    rd_chk("R4 tx enabled after combo", 6'h04, 8'h0C);

    // R13 no-op and reserved codes
    wr(6'h08, 8'h4F); wr(6'h08, 8'h6C); wr(6'h08, 8'h73); wr(6'h08, 8'h00);
    rd_chk("R13 status unchanged", 6'h04, 8'h0C);
    rd_chk("R13 isr unchanged", 6'h14, 8'h01);
    check("R13 rx still enabled", {7'd0, rx_ready}, 8'h01);
    rd_chk("R13 pointer unchanged", 6'h00, 8'h11);

    // R9 break with receiver disabled
    wr(6'h08, 8'h02);
    check("R4 rx disable", {7'd0, rx_ready}, 8'h00);
    pulse_break();
    rx_exp_q.push_back(8'h00);
    rd_chk("R9 break queued while disabled", 6'h04, 8'h0D);
    rd_chk("R9 isr break bit", 6'h14, 8'h05);
    rd_rx("R9 break byte is zero");
    wr(6'h08, 8'h10);
    rd_chk("R2 first mode kept", 6'h00, 8'h40);

    check("R7 all tx bytes seen", 8'(tx_exp_q.size()), 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule